// File: doc/BRIEF.md
# Per-Pin Expected-Level Input Filter

This block conditions an eight-pin input port before the pin values reach a readable data register. A two-flop synchroniser brings each pin into the clock domain. Each pin then either goes straight to its data bit, or goes through its own filter. Software chooses between the two with a per-pin enable bit.

An enabled pin is sampled only on strobes from a shared free-running prescaler. A 2-bit select sets the strobe spacing. The filter is deliberately one-sided. Each pin has a mode bit that names the level it expects. A sample of that expected level is stored only once the level has been stable over three consecutive strobes. A sample of the opposite level is stored on the first strobe that sees it.

Software reaches the block through a small synchronous bus with four addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Enable | read/write |
| 1 | Mode | read/write |
| 2 | Data | read only |
| 3 | Strobe select | read/write |

Top module: `exp_level_filter`

## Requirements
- R1: After reset the enable, mode, data and select registers all read zero: every pin is unfiltered and every pin expects 0.
- R2: A write with `bus_we` high stores `bus_wdata` in the addressed register. Address 0 is enable, address 1 is mode and address 3 is the select, which takes bits 1:0. Reads are combinational and return enable, mode, data or the select (zero-extended) for addresses 0, 1, 2 and 3. A write to address 2 has no effect.
- R3: When enable bit n is 0, data bit n shows the pin value that was present three rising edges earlier, updated every clock.
- R4: Select code 0, 1, 2 and 3 spaces the sampling strobes 2, 8, 32 and 128 clocks apart.
- R5: When a pin is enabled and its mode bit equals the sampled level, that level is stored only on the third consecutive strobe that sees the same level.
- R6: When a pin is enabled and the sampled level differs from its mode bit, that level is stored on the first strobe that sees it.
- R7: A sample that differs from the previous sample restarts the stability count. An expected-level pulse seen by fewer than three strobes therefore never reaches the data register.
- R8: Each pin's filter, enable and mode act on that pin alone.
- R9: The data bit of an enabled pin changes only on a clock edge at which a strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Asynchronous port pins |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| port_q | output | 8 | Data register contents |

## Verification
The assertions assume that the bus inputs are always known values and that `bus_we` is sampled only on rising edges. Pins may be fully asynchronous, because the properties observe only the synchronised copy. The bench changes every input on the falling edge, well clear of the sampling edge. It holds pin levels for random spans scaled to the strobe period, so that both stable runs and short glitches reach the filters under every select code.

// File: rtl/exp_level_filter.sv
module exp_level_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic [W-1:0] port_q
);
  localparam int PRE_W = 7;
  localparam logic [1:0] A_EN = 2'd0, A_MODE = 2'd1, A_DATA = 2'd2, A_SEL = 2'd3;

  logic [W-1:0] en_q, mode_q, data_q, s1_q, s2_q, last_q;
  logic [1:0]   sel_q;
  logic [PRE_W-1:0] pre_q, mask;
  logic [1:0]   run_q [W];
  logic         strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; mode_q <= '0; sel_q <= '0;
      s1_q <= '0; s2_q <= '0; pre_q <= '0;
    end else begin
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      pre_q <= pre_q + 1'b1;
      if (bus_we) begin
        case (bus_addr)
          A_EN:    en_q   <= bus_wdata;
          A_MODE:  mode_q <= bus_wdata;
          A_SEL:   sel_q  <= bus_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel_q)
      2'd0:    mask = 7'd1;
      2'd1:    mask = 7'd7;
      2'd2:    mask = 7'd31;
      default: mask = 7'd127;
    endcase
  end

  assign strobe = &(pre_q | ~mask);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic same;
    logic [1:0] run_nx;
    assign same   = (run_q[i] != 2'd0) && (s2_q[i] == last_q[i]);
    assign run_nx = !same ? 2'd1 : (run_q[i] == 2'd3 ? 2'd3 : run_q[i] + 2'd1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q[i] <= 2'd0; last_q[i] <= 1'b0; data_q[i] <= 1'b0;
      end else if (!en_q[i]) begin
        run_q[i]  <= 2'd0;
        data_q[i] <= s2_q[i];
      end else if (strobe) begin
        run_q[i]  <= run_nx;
        last_q[i] <= s2_q[i];
        if (s2_q[i] != mode_q[i] || run_nx == 2'd3)
          data_q[i] <= s2_q[i];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_MODE:  bus_rdata = mode_q;
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = {{(W-2){1'b0}}, sel_q};
    endcase
  end

  assign port_q = data_q;
endmodule

// File: rtl/exp_level_filter_chk.sv
module exp_level_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] en_q,
  input logic [7:0] mode_q,
  input logic [7:0] s2_q,
  input logic [7:0] data_q,
  input logic [1:0] sel_q,
  input logic       strobe,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata
);
  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd0 |=> en_q == $past(bus_wdata));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd1 |=> mode_q == $past(bus_wdata));

  // R3
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q ^ $past(s2_q)) & ~$past(en_q)) == 8'h00);

  // R6
  opposite_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ((data_q ^ $past(s2_q)) & $past(en_q & (s2_q ^ mode_q))) == 8'h00);

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ((data_q ^ $past(data_q)) & $past(en_q)) == 8'h00);

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && sel_q != 2'd0 |=> !strobe);
endmodule

bind exp_level_filter exp_level_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .mode_q(mode_q), .s2_q(s2_q),
  .data_q(data_q), .sel_q(sel_q), .strobe(strobe), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/exp_level_filter_bench.sv
module exp_level_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, port_q;

  always #2 clk = ~clk;

  exp_level_filter u_exp_level_filter (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_q(port_q)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  bit [7:0] m_en, m_mode, m_data, m_s1, m_s2, m_last;
  int m_run [8];
  int m_tick;
  int m_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_data = 0; m_s1 = 0; m_s2 = 0; m_last = 0;
      m_tick = 0; m_sel = 0;
      foreach (m_run[i]) m_run[i] = 0;
    end else begin
      int per;
      bit hit;
      per = 2 ** (1 + 2 * m_sel);
      hit = (m_tick % per) == per - 1;
      for (int i = 0; i < 8; i++) begin
        if (!m_en[i]) begin
          m_data[i] = m_s2[i];
          m_run[i] = 0;
        end else if (hit) begin
          if (m_run[i] > 0 && m_s2[i] == m_last[i]) m_run[i] = (m_run[i] < 3) ? m_run[i] + 1 : 3;
          else m_run[i] = 1;
          m_last[i] = m_s2[i];
          if (m_s2[i] != m_mode[i] || m_run[i] >= 3) m_data[i] = m_s2[i];
        end
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_tick = (m_tick + 1) % 128;
      if (bus_we) begin
        if (bus_addr == 0) m_en = bus_wdata;
        if (bus_addr == 1) m_mode = bus_wdata;
        if (bus_addr == 3) m_sel = bus_wdata[1:0];
      end
    end
  end

  function automatic bit [7:0] m_rdata();
    case (bus_addr)
      2'd0: return m_en;
      2'd1: return m_mode;
      2'd2: return m_data;
      default: return 8'(m_sel);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R3 R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(port_q == m_data, "R5/R6/R3 model data", port_q, m_data);
      chk(bus_rdata == m_rdata(), "R2 model read", bus_rdata, m_rdata());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    tick(3);
    @(negedge clk) rst_n = 1'b1;
    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'h00, "R1 reset value", v, 0);
    end

    // R2 read-back and ignored data write
    wr(2'd1, 8'h3C); rd(2'd1, v); chk(v == 8'h3C, "R2 mode readback", v, 8'h3C);
    wr(2'd3, 8'hFE); rd(2'd3, v); chk(v == 8'h02, "R2 select readback", v, 8'h02);
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 8'h00, "R2 enable readback", v, 0);
    pin_in = 8'h00; tick(5);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk(v == 8'h00, "R2 data write ignored", v, 0);

    // R3 bypass latency
    pin_in = 8'hA5;
    tick(2); chk(port_q == 8'h00, "R3 not yet", port_q, 0);
    tick(1); chk(port_q == 8'hA5, "R3 three-edge latency", port_q, 8'hA5);

    // directed timing per select code on pin 0, others bypassed (R4 R5 R6 R7 R8)
    for (int s = 0; s < 4; s++) begin
      int per, n;
      per = 2 ** (1 + 2 * s);
      wr(2'd3, 8'(s)); wr(2'd1, 8'h00); wr(2'd0, 8'h01);
      pin_in = 8'h54; tick(3 * per + 10);
      chk(port_q[0] == 1'b0, "R5 settle low", port_q[0], 0);
      pin_in = 8'h55; n = 0;
      while (port_q[0] == 1'b0 && n < 400) begin tick(); n++; end
      chk(n >= 3 && n <= per + 2, "R6 opposite stored on first strobe", n, per + 2);
      chk(port_q[7:1] == 7'h2A, "R8 bypassed pins unaffected", port_q[7:1], 7'h2A);
      tick(3 * per);
      pin_in = 8'h54; n = 0;
      while (port_q[0] == 1'b1 && n < 800) begin tick(); n++; end
      chk(n >= 2 * per + 3 && n <= 3 * per + 2, "R4/R5 expected level after three strobes", n, 2 * per + 3);
      pin_in = 8'h55; tick(3 * per + 10);
      pin_in = 8'h54; tick(per);
      pin_in = 8'h55; n = 0;
      for (int k = 0; k < 4 * per; k++) begin tick(); if (!port_q[0]) n++; end
      chk(n == 0, "R7 short expected pulse rejected", n, 0);
    end

    // random patterns under each select code, model compared every clock
    for (int s = 0; s < 4; s++) begin
      int per;
      per = 2 ** (1 + 2 * s);
      wr(2'd3, 8'(s)); wr(2'd0, 8'($urandom)); wr(2'd1, 8'($urandom));
      for (int k = 0; k < 3000; k++) begin
        @(negedge clk);
        if ($urandom % per == 0) pin_in = pin_in ^ (8'h01 << ($urandom % 8));
        if (k == 1500) begin bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'($urandom); end
        else bus_we = 1'b0;
        bus_addr = 2'($urandom);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule